// File: doc/BRIEF.md
# Runtime-Tunable Streaming Decimator

This block thins a stream of 8-bit fixed-point samples. It passes the first sample of every group of D and drops the other D-1. The factor D is not fixed when the hardware is built. Before each group, the block takes one control token from a separate valid/ready channel. That token sets the length of the group that follows, so a running stream can move from D=4 to D=3, or to any value in 1..16, without rebuilding the hardware.

A group runs as follows. The block waits for a control token and accepts it. It then accepts exactly D data samples, one per handshake. The first of these is offered on the output channel and goes out in the same cycle it is accepted. When the output is not ready, the block holds that first sample and stalls the input, so nothing is lost. The remaining D-1 samples are accepted as fast as the source offers them, and the output has no effect on them. After the last sample of the group the block waits for the next control token. A control token that arrives while a group is running has to wait until the group ends.

Top module: `tune_decim`

## Requirements
- R1: After a synchronous reset the block sits in its idle state with the phase cleared: ctl_ready=1, in_ready=0, out_valid=0.
- R2: While idle, in_ready is 0. Once a control token has been accepted, ctl_ready stays 0 until the group of D samples is complete.
- R3: A control value v on ctl_factor gives D=1 when v=0, D=16 when v>16, and D=v otherwise.
- R4: In each group, only the first accepted sample produces an output. While any of the other D-1 samples is presented, out_valid is 0 and in_ready is 1, whatever the state of out_ready.
- R5: The output word equals the first sample of its group (out_data = in_data at the moment of transfer). Each accepted sample counts as exactly one of the D samples.
- R6: On the first phase, while out_ready is 0, out_valid is 1 and in_ready is 0, and the sample stays on offer until out_ready rises.
- R7: ctl_ready returns to 1 in the cycle after the D-th sample is accepted. A control token held valid during a running group is not taken before then, and it sets the length of the next group only.
- R8: Back-to-back groups with different factors (for example 4, then 3) each use their own factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ctl_valid | input | 1 | Control token valid |
| ctl_ready | output | 1 | Block can take a control token (idle) |
| ctl_factor | input | 5 | Requested decimation factor, clamped as in R3 |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts the input sample |
| in_data | input | 8 | Input sample |
| out_valid | output | 1 | Kept sample is on offer |
| out_ready | input | 1 | Downstream accepts the output |
| out_data | output | 8 | Kept sample |

## Verification
A wrong phase count or a wrong stored factor shows up at the control port. ctl_ready rises one or more handshakes too early or too late, and in the cycle after the expected D-th transfer the bench sees the wrong ctl_ready level. A phase that does not start at zero makes out_valid appear on a sample other than the first, or fail to appear on the first, and this is visible on the very first data beat of the group. A stall that drops data shows as in_ready high while out_valid is high and out_ready is low, so it is caught in the same cycle. The bench sweeps every raw control value from 0 to 20 with varied stall lengths, so each clamp boundary and each group length is covered.

// File: rtl/tune_decim_pkg.sv
package tune_decim_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dec_state_t;

  // Effective factor for a raw control value: zero maps to one, large values saturate.
  function automatic int unsigned eff_factor(input int unsigned raw, input int unsigned max_f);
    if (raw == 0)
      return 1;
    else if (raw > max_f)
      return max_f;
    else
      return raw;
  endfunction

  // Next phase value inside a group of length (top + 1).
  function automatic int unsigned next_phase(input int unsigned ph, input int unsigned top);
    return (ph >= top) ? 0 : ph + 1;
  endfunction

endpackage

// File: rtl/tune_decim_phase.sv
module tune_decim_phase
  import tune_decim_pkg::*;
#(
  parameter int MAX_FACTOR = 16,
  parameter int FACT_W     = 5,
  parameter int PH_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [FACT_W-1:0] raw_factor,
  output logic [PH_W-1:0]   phase,
  output logic [PH_W-1:0]   factor_m1,
  output logic              last_phase
);

  logic [PH_W-1:0] load_m1;

  always_comb begin
    load_m1 = PH_W'(eff_factor(32'(raw_factor), 32'(MAX_FACTOR)) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      factor_m1 <= '0;
    end else if (load) begin
      phase     <= '0;
      factor_m1 <= load_m1;
    end else if (step) begin
      phase <= PH_W'(next_phase(32'(phase), 32'(factor_m1)));
    end
  end

  assign last_phase = (phase == factor_m1);

endmodule

// File: rtl/tune_decim_fsm.sv
module tune_decim_fsm
  import tune_decim_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ctl_fire,
  input  logic data_fire,
  input  logic last_phase,
  output logic running
);

  dec_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (ctl_fire) st_d = ST_RUN;
      ST_RUN:  if (data_fire && last_phase) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign running = (st_q == ST_RUN);

endmodule

// File: rtl/tune_decim_route.sv
module tune_decim_route #(
  parameter int DATA_W = 8
) (
  input  logic              running,
  input  logic              keep_phase,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              ctl_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  always_comb begin
    ctl_ready = !running;
    out_data  = in_data;
    if (!running) begin
      in_ready  = 1'b0;
      out_valid = 1'b0;
    end else if (keep_phase) begin
      in_ready  = out_ready;
      out_valid = in_valid;
    end else begin
      in_ready  = 1'b1;
      out_valid = 1'b0;
    end
  end

endmodule

// File: rtl/tune_decim.sv
module tune_decim #(
  parameter  int DATA_W     = 8,
  parameter  int MAX_FACTOR = 16,
  localparam int FACT_W     = $clog2(MAX_FACTOR + 1),
  localparam int PH_W       = (MAX_FACTOR > 1) ? $clog2(MAX_FACTOR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_valid,
  output logic              ctl_ready,
  input  logic [FACT_W-1:0] ctl_factor,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  // Named internal events, visible to the bound checker.
  logic            running;
  logic            keep_phase;
  logic            last_phase;
  logic            ctl_fire;
  logic            data_fire;
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] fm1_q;

  assign ctl_fire   = ctl_valid && ctl_ready;
  assign data_fire  = in_valid && in_ready;
  assign keep_phase = (phase_q == '0);

  tune_decim_phase #(
    .MAX_FACTOR (MAX_FACTOR),
    .FACT_W     (FACT_W),
    .PH_W       (PH_W)
  ) u_phase (
    .clk        (clk),
    .rst        (rst),
    .load       (ctl_fire),
    .step       (data_fire),
    .raw_factor (ctl_factor),
    .phase      (phase_q),
    .factor_m1  (fm1_q),
    .last_phase (last_phase)
  );

  tune_decim_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ctl_fire   (ctl_fire),
    .data_fire  (data_fire),
    .last_phase (last_phase),
    .running    (running)
  );

  tune_decim_route #(
    .DATA_W (DATA_W)
  ) u_route (
    .running    (running),
    .keep_phase (keep_phase),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .ctl_ready  (ctl_ready),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

endmodule

// File: rtl/tune_decim_chk.sv
module tune_decim_chk #(
  parameter int PH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ctl_ready,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic            ctl_fire,
  input logic            data_fire,
  input logic            last_phase,
  input logic [PH_W-1:0] phase,
  input logic [PH_W-1:0] factor_m1
);

  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    ctl_ready |-> !in_ready); // R2

  AST_CTL_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    ctl_fire |=> !ctl_ready); // R2

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
    !ctl_ready |-> (phase <= factor_m1)); // R3

  AST_OUT_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (phase == '0)); // R4

  AST_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (phase == '0)); // R6

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (data_fire && !last_phase) |=> (phase == $past(phase) + 1'b1)); // R5

  AST_GROUP_END: assert property (@(posedge clk) disable iff (rst)
    (data_fire && last_phase) |=> ctl_ready); // R7

endmodule

bind tune_decim tune_decim_chk #(.PH_W(PH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctl_ready  (ctl_ready),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .ctl_fire   (ctl_fire),
  .data_fire  (data_fire),
  .last_phase (last_phase),
  .phase      (phase_q),
  .factor_m1  (fm1_q)
);

// File: tb/tune_decim_bench.sv
module tune_decim_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXF       = 16;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst;
  logic       ctl_valid;
  logic       ctl_ready;
  logic [4:0] ctl_factor;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [7:0] seq = 8'h11;

  always #(CLK_PERIOD/2) clk = ~clk;

  tune_decim u_tune_decim (
    .clk(clk), .rst(rst),
    .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_factor(ctl_factor),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model_factor(input int raw);
    if (raw < 1) return 1;
    if (raw > MAXF) return MAXF;
    return raw;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  // One group: control token raw, then the samples. nxt is held valid during the group (R7).
  task automatic run_group(input int raw, input int nxt, input int stall);
    int d;
    logic [7:0] first;
    d = model_factor(raw);
    @(negedge clk);
    ctl_valid = 1'b1; ctl_factor = 5'(raw); in_valid = 1'b1; in_data = seq; out_ready = 1'b1;
    #1;
    chk("R2", "idle ctl_ready", int'(ctl_ready), 1);
    chk("R2", "idle in_ready", int'(in_ready), 0);
    chk("R1", "idle out_valid", int'(out_valid), 0);
    @(posedge clk);
    for (int k = 0; k < d; k++) begin
      @(negedge clk);
      ctl_valid = 1'b1; ctl_factor = 5'(nxt);
      in_valid = 1'b1; in_data = seq;
      if (k == 0) begin
        first = seq;
        for (int s = 0; s < stall; s++) begin
          out_ready = 1'b0;
          #1;
          chk("R6", "stall out_valid", int'(out_valid), 1);
          chk("R6", "stall in_ready", int'(in_ready), 0);
          chk("R6", "stall out_data", int'(out_data), int'(first));
          @(negedge clk);
        end
        out_ready = 1'b1;
        #1;
        chk("R4", "first out_valid", int'(out_valid), 1);
        chk("R5", "first out_data", int'(out_data), int'(first));
        chk("R2", "run ctl_ready", int'(ctl_ready), 0);
      end else begin
        out_ready = k[0];
        #1;
        chk("R4", "drop out_valid", int'(out_valid), 0);
        chk("R4", "drop in_ready", int'(in_ready), 1);
        chk("R7", "mid ctl_ready", int'(ctl_ready), 0);
      end
      @(posedge clk);
      seq = seq + 8'd7;
    end
    @(negedge clk);
    ctl_valid = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    #1;
    chk("R7", $sformatf("end ctl_ready raw=%0d", raw), int'(ctl_ready), 1);
    chk("R3", "end out_valid", int'(out_valid), 0);
  endtask

  initial begin
    rst = 1'b1; ctl_valid = 1'b0; ctl_factor = '0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "reset ctl_ready", int'(ctl_ready), 1);
    chk("R1", "reset in_ready", int'(in_ready), 0);
    chk("R1", "reset out_valid", int'(out_valid), 0);

    // R3 sweep of every raw control value across the clamp boundaries.
    for (int r = 0; r <= 20; r++) run_group(r, (r * 5) % 21, r % 3);

    // R8: factor switch between groups, 4 then 3 then 4.
    run_group(4, 3, 1);
    run_group(3, 4, 0);
    run_group(4, 1, 2);

    // R1: reset in the middle of a group returns to idle.
    @(negedge clk);
    ctl_valid = 1'b1; ctl_factor = 5'd6; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ctl_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    #1;
    chk("R1", "midreset ctl_ready", int'(ctl_ready), 1);
    chk("R1", "midreset in_ready", int'(in_ready), 0);
    run_group(2, 0, 0);

    finish_run();
  end
endmodule